// File: doc/BRIEF.md
# Banked GPIO Pin Controller with Row-Packed Configuration

The block drives a parameterised set of general-purpose pins. Each pin has an 8-bit configuration byte. The bytes are packed side by side into the data word of a small Wishbone-style slave port, so one bus write reprograms a whole row of pins at once. There is no per-pin write strobe. Software therefore has to keep a shadow copy of each row and rewrite every byte in it.

Three fields of each byte set who owns the pin:

- The low two bits of the bank field hand the pin's output value, output enable and input enable either to the bus (bank 0) or to one of three peripheral ports (banks 1 to 3).
- The pull-up and pull-down enables always stay with the bus.
- The top bank bit is never used to choose a peripheral. Instead it arms a test port. When the test port's pin index names that pin, the test port overrides the pad controls and the peripheral routing of that pin.

Top module: `gpio_bank_mux`

## Requirements
- R1: After reset every configuration byte is zero. On every pin, pad_oe, pad_ie, pad_pu, pad_pd and every per_i_o bit are 0. A read of any implemented row returns bytes whose only possibly set bit is bit 4, which holds the pad input level.
- R2: Configuration byte layout:
  - bit 0: output enable
  - bit 1: input enable
  - bit 2: pull-up enable
  - bit 3: pull-down enable
  - bit 4: data
  - bits 7:5: bank select
- R3: LANES = DW/8 pins share one row. Pin p sits at word address p/LANES, in byte lane p%LANES, which is data bits 8*(p%LANES)+7 down to 8*(p%LANES).
- R4: A write to an implemented row updates every byte of that row in the same cycle.
- R5: wb_ack_o goes high for exactly one cycle, on the clock after a cycle in which wb_cyc_i and wb_stb_i are high and wb_ack_o is low. Read data is valid while wb_ack_o is high.
- R6: Rows at or beyond ceil(NPINS/LANES) read as zero, and writes to them change nothing.
- R7: Data bit behaviour:
  - A read of bit 4 returns the stored data bit when the stored output enable is 1, and the pad input otherwise.
  - A written byte whose bit 0 is 0 leaves the stored data bit unchanged.
- R8: With bank bits 6:5 equal to 0 and no test override, pad_o, pad_oe and pad_ie follow the byte's data, output-enable and input-enable bits.
- R9: With bank bits 6:5 equal to k in 1..3 and no test override, peripheral k alone drives pad_o, pad_oe and pad_ie. Peripheral k is slice k-1 of the per_*_i buses. pad_pu and pad_pd still follow bits 2 and 3 of the byte.
- R10: Bank bit 7 has no effect on peripheral selection when the pin is not addressed by the test port.
- R11: When a pin's bank bit 7 is 1 and tst_sel_i equals its index, the test port inputs drive that pin's pad_o, pad_oe, pad_ie, pad_pu and pad_pd. In that case tst_bank_i replaces bits 6:5 for peripheral routing.
- R12: per_i_o bit for peripheral k of pin p equals pad_i[p] AND pad_ie[p] when the pin's effective bank is k. In every other case that bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_adr_i | input | AW | Row (word) address |
| wb_dat_i | input | DW | Write data, one byte per pin |
| wb_dat_o | output | DW | Read data, valid with ack |
| wb_we_i | input | 1 | Write enable |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Strobe |
| wb_ack_o | output | 1 | One-cycle acknowledge |
| pad_i | input | NPINS | Pad input levels |
| pad_o | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |
| pad_ie | output | NPINS | Pad input enables |
| pad_pu | output | NPINS | Pull-up enables |
| pad_pd | output | NPINS | Pull-down enables |
| per_o_i | input | 3*NPINS | Peripheral output values, slice k-1 for bank k |
| per_oe_i | input | 3*NPINS | Peripheral output enables |
| per_ie_i | input | 3*NPINS | Peripheral input enables |
| per_i_o | output | 3*NPINS | Gated pad inputs to peripherals |
| tst_sel_i | input | IW | Pin index addressed by the test port |
| tst_bank_i | input | 2 | Test-port bank choice for routing |
| tst_o_i | input | 1 | Test-port output value |
| tst_oe_i | input | 1 | Test-port output enable |
| tst_ie_i | input | 1 | Test-port input enable |
| tst_pu_i | input | 1 | Test-port pull-up |
| tst_pd_i | input | 1 | Test-port pull-down |

## Verification
The bench builds the block with NPINS=6, DW=16, AW=2 and IW=3. This gives two lanes per row and three implemented rows. The fourth address is unimplemented, so the zero-read and write-ignore rule can be exercised.

At this size the bench sweeps all 256 values of each pin byte through every row, and the other lane of the row carries a second varying byte. Every bank code, every oe/data combination and every arming of the test override therefore appears on every pin. The test index is moved onto and off the written pins, including an index that names no pin.

// File: rtl/gpio_bank_mux.sv
module gpio_bank_mux #(
  parameter int NPINS = 16,
  parameter int DW    = 64,
  parameter int AW    = 4,
  parameter int IW    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      wb_adr_i,
  input  logic [DW-1:0]      wb_dat_i,
  output logic [DW-1:0]      wb_dat_o,
  input  logic               wb_we_i,
  input  logic               wb_cyc_i,
  input  logic               wb_stb_i,
  output logic               wb_ack_o,
  input  logic [NPINS-1:0]   pad_i,
  output logic [NPINS-1:0]   pad_o,
  output logic [NPINS-1:0]   pad_oe,
  output logic [NPINS-1:0]   pad_ie,
  output logic [NPINS-1:0]   pad_pu,
  output logic [NPINS-1:0]   pad_pd,
  input  logic [3*NPINS-1:0] per_o_i,
  input  logic [3*NPINS-1:0] per_oe_i,
  input  logic [3*NPINS-1:0] per_ie_i,
  output logic [3*NPINS-1:0] per_i_o,
  input  logic [IW-1:0]      tst_sel_i,
  input  logic [1:0]         tst_bank_i,
  input  logic               tst_o_i,
  input  logic               tst_oe_i,
  input  logic               tst_ie_i,
  input  logic               tst_pu_i,
  input  logic               tst_pd_i
);
  localparam int LANES = DW / 8;
  localparam int ROWS  = (NPINS + LANES - 1) / LANES;
  localparam logic [31:0] ROWS_W = 32'(ROWS);

  logic [7:0]    cfg   [NPINS];
  logic [7:0]    wnext [NPINS];
  logic [7:0]    rbyte [NPINS];
  logic [NPINS-1:0] wsel;
  logic          ack_q;
  logic [DW-1:0] rd_q, rd_word;

  wire req = wb_cyc_i & wb_stb_i & ~ack_q;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    localparam int ROW  = p / LANES;
    localparam int LANE = p % LANES;
    wire [7:0] wb   = wb_dat_i[8*LANE +: 8];
    assign wsel[p]  = req & wb_we_i & (wb_adr_i == AW'(ROW));
    assign wnext[p] = {wb[7:5], wb[0] ? wb[4] : cfg[p][4], wb[3:0]};
    assign rbyte[p] = {cfg[p][7:5], cfg[p][0] ? cfg[p][4] : pad_i[p], cfg[p][3:0]};

    wire       ovr = cfg[p][7] & (tst_sel_i == IW'(p));
    wire [1:0] bk  = ovr ? tst_bank_i : cfg[p][6:5];
    wire po  = (bk == 2'd1) ? per_o_i[p]  : (bk == 2'd2) ? per_o_i[NPINS+p]  : per_o_i[2*NPINS+p];
    wire poe = (bk == 2'd1) ? per_oe_i[p] : (bk == 2'd2) ? per_oe_i[NPINS+p] : per_oe_i[2*NPINS+p];
    wire pie = (bk == 2'd1) ? per_ie_i[p] : (bk == 2'd2) ? per_ie_i[NPINS+p] : per_ie_i[2*NPINS+p];

    assign pad_o[p]  = ovr ? tst_o_i  : (bk == 2'd0) ? cfg[p][4] : po;
    assign pad_oe[p] = ovr ? tst_oe_i : (bk == 2'd0) ? cfg[p][0] : poe;
    assign pad_ie[p] = ovr ? tst_ie_i : (bk == 2'd0) ? cfg[p][1] : pie;
    assign pad_pu[p] = ovr ? tst_pu_i : cfg[p][2];
    assign pad_pd[p] = ovr ? tst_pd_i : cfg[p][3];

    for (genvar k = 0; k < 3; k++) begin : g_per
      assign per_i_o[k*NPINS+p] = pad_i[p] & pad_ie[p] & (bk == 2'(k+1));
    end

    // R12
    per_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pad_ie[p] |-> !(per_i_o[p] | per_i_o[NPINS+p] | per_i_o[2*NPINS+p]));
    // R12
    per_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({per_i_o[p], per_i_o[NPINS+p], per_i_o[2*NPINS+p]}));
  end

  always_comb begin
    rd_word = '0;
    for (int p = 0; p < NPINS; p++)
      if (wb_adr_i == AW'(p / LANES)) rd_word[8*(p % LANES) +: 8] = rbyte[p];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      rd_q  <= '0;
      for (int p = 0; p < NPINS; p++) cfg[p] <= 8'h00;
    end else begin
      ack_q <= req;
      if (req && !wb_we_i) rd_q <= rd_word;
      for (int p = 0; p < NPINS; p++)
        if (wsel[p]) cfg[p] <= wnext[p];
    end
  end

  assign wb_ack_o = ack_q;
  assign wb_dat_o = rd_q;

  // R5
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ack_o |=> !wb_ack_o);
  // R5
  ack_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc_i && wb_stb_i && !wb_ack_o) |=> wb_ack_o);
  // R6
  unimpl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc_i && wb_stb_i && !wb_ack_o && !wb_we_i && ({{(32-AW){1'b0}}, wb_adr_i} >= ROWS_W))
    |=> (wb_dat_o == '0));
endmodule

// File: tb/test_gpio_bank_mux.sv
module test_gpio_bank_mux;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 6;
  localparam int DW = 16;
  localparam int AW = 2;
  localparam int IW = 3;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] adr = '0;
  logic [DW-1:0] dat = '0;
  logic [DW-1:0] dat_o;
  logic we = 0, cyc = 0, stb = 0, ack;
  logic [N-1:0] pad_i = '0, pad_o, pad_oe, pad_ie, pad_pu, pad_pd;
  logic [3*N-1:0] per_o = '0, per_oe = '0, per_ie = '0, per_i;
  logic [IW-1:0] tsel = '1;
  logic [1:0] tbank = '0;
  logic t_o = 0, t_oe = 0, t_ie = 0, t_pu = 0, t_pd = 0;

  int checks = 0, errors = 0;
  logic [7:0] m [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank_mux #(.NPINS(N), .DW(DW), .AW(AW), .IW(IW)) i_gpio_bank_mux (
    .clk(clk), .rst_n(rst_n), .wb_adr_i(adr), .wb_dat_i(dat), .wb_dat_o(dat_o),
    .wb_we_i(we), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_ack_o(ack),
    .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe), .pad_ie(pad_ie),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .per_o_i(per_o), .per_oe_i(per_oe),
    .per_ie_i(per_ie), .per_i_o(per_i), .tst_sel_i(tsel), .tst_bank_i(tbank),
    .tst_o_i(t_o), .tst_oe_i(t_oe), .tst_ie_i(t_ie), .tst_pu_i(t_pu), .tst_pd_i(t_pd));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); adr = a; dat = d; we = 1; cyc = 1; stb = 1;
    @(negedge clk); cyc = 0; stb = 0; we = 0;
    if (32'(a) < 3)
      for (int l = 0; l < 2; l++) begin
        logic [7:0] b = d[8*l +: 8];
        int p = int'(a) * 2 + l;
        m[p] = {b[7:5], b[0] ? b[4] : m[p][4], b[3:0]};
      end
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic k);
    @(negedge clk); adr = a; we = 0; cyc = 1; stb = 1;
    @(negedge clk); d = dat_o; k = ack; cyc = 0; stb = 0;
  endtask

  function automatic logic [DW-1:0] exp_row(input int r);
    logic [DW-1:0] w = '0;
    if (r < 3)
      for (int l = 0; l < 2; l++) begin
        int p = r * 2 + l;
        w[8*l +: 8] = {m[p][7:5], m[p][0] ? m[p][4] : pad_i[p], m[p][3:0]};
      end
    return w;
  endfunction

  task automatic check_pins();
    logic [N-1:0] eo, eoe, eie, epu, epd;
    logic [3*N-1:0] epi;
    epi = '0;
    for (int p = 0; p < N; p++) begin
      logic ov = m[p][7] && (int'(tsel) == p);
      logic [1:0] bk = ov ? tbank : m[p][6:5];
      int ix = (int'(bk) - 1) * N + p;
      if (ov) begin
        eo[p] = t_o; eoe[p] = t_oe; eie[p] = t_ie;
      end else if (bk == 0) begin
        eo[p] = m[p][4]; eoe[p] = m[p][0]; eie[p] = m[p][1];
      end else begin
        eo[p] = per_o[ix]; eoe[p] = per_oe[ix]; eie[p] = per_ie[ix];
      end
      epu[p] = ov ? t_pu : m[p][2];
      epd[p] = ov ? t_pd : m[p][3];
      if (bk != 0) epi[ix] = pad_i[p] & eie[p];
    end
    chk("R7 R8 R9 R10 R11 pad_o", 32'(pad_o), 32'(eo));
    chk("R8 R9 R10 R11 pad_oe", 32'(pad_oe), 32'(eoe));
    chk("R8 R9 R10 R11 pad_ie", 32'(pad_ie), 32'(eie));
    chk("R9 R11 pad_pu", 32'(pad_pu), 32'(epu));
    chk("R9 R11 pad_pd", 32'(pad_pd), 32'(epd));
    chk("R12 per_i", 32'(per_i), 32'(epi));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    logic k;
    for (int p = 0; p < N; p++) m[p] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    pad_i = 6'b101101;
    per_ie = '1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pad_oe", 32'(pad_oe), 0);
    chk("R1 pad_ie", 32'(pad_ie), 0);
    chk("R1 pulls", 32'({pad_pu, pad_pd}), 0);
    chk("R1 per_i", 32'(per_i), 0);
    chk("R1 ack idle", 32'(ack), 0);
    for (int r = 0; r < 3; r++) begin
      bus_rd(AW'(r), rd, k);
      chk("R1 R2 reset read", 32'(rd), 32'(exp_row(r)));
    end

    // R5 ack pulse with request held
    @(negedge clk); adr = 0; we = 0; cyc = 1; stb = 1;
    @(negedge clk); chk("R5 ack first", 32'(ack), 1);
    @(negedge clk); chk("R5 ack drops", 32'(ack), 0);
    @(negedge clk); chk("R5 ack again", 32'(ack), 1);
    cyc = 0; stb = 0;
    @(negedge clk); chk("R5 ack idle", 32'(ack), 0);

    // R2 R3 R4 R7 R8..R12 sweep of every byte value in every row
    for (int v = 0; v < 256; v++)
      for (int r = 0; r < 3; r++) begin
        logic [7:0] b1 = 8'(v * 37 + 11);
        pad_i = 6'(v * 7 + r);
        bus_wr(AW'(r), {b1, 8'(v)});
        bus_rd(AW'(r), rd, k);
        chk("R5 read ack", 32'(k), 1);
        chk("R2 R3 R4 R7 row read", 32'(rd), 32'(exp_row(r)));
        for (int q = 0; q < 4; q++) begin
          @(negedge clk);
          pad_i  = 6'(v * 7 + q * 13 + r);
          per_o  = 18'(v * 3779 + q * 911);
          per_oe = 18'(v * 1237 + q * 4099 + r);
          per_ie = 18'(v * 2711 + q * 613 + 5);
          tsel   = (q == 3) ? 3'd7 : 3'(r * 2 + (q & 1));
          tbank  = 2'(v + q);
          t_o = q[0]; t_oe = q[1]; t_ie = ~q[0]; t_pu = v[0]; t_pd = q[1] ^ v[1];
          #1 check_pins();
        end
      end

    // R6 unimplemented row
    bus_wr(AW'(3), 16'hFFFF);
    #1 check_pins();
    bus_rd(AW'(3), rd, k);
    chk("R6 unimplemented read", 32'(rd), 0);
    chk("R6 unimplemented ack", 32'(k), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule